// File: doc/BRIEF.md
# Write Burst CRC Checker

This block sits on the receive side of one byte lane of a double-data-rate memory write path. It gathers the data beats of one write burst and folds them into an 8-bit checksum with generator x^8 + x^2 + x + 1. When the controller's checksum byte arrives at the end of the burst, the block compares it with the local result. On a difference it pulls an active-low alert output low for a fixed number of clocks. It also increments a saturating error counter and sets a sticky error flag.

The checksum always covers a frame of (BEATS+1)*LANE_W bits, which is 72 bits with the default values. Slots 0 to BEATS-1 hold the data beats. The last slot carries no data and counts as all ones. When a burst is chopped to CHOP_BEATS beats, the slots that were not sent also count as all ones. All inputs are already in the core clock domain.

Top module: `wburst_crc_chk`

## Requirements
- R1: The checksum register is cleared at the start of each burst. The frame is shifted in one bit at a time: slot 0 first, and lane bit 0 first within each slot. For each bit, feedback = crc[7] XOR bit, and the new crc = {crc[6:0],0} XOR (feedback ? 8'h07 : 8'h00).
- R2: With `chop` low at `burst_start`, the burst takes BEATS beats (default 8) into slots 0 to BEATS-1, and the final slot of the frame is all ones.
- R3: With `chop` high at `burst_start`, the burst takes CHOP_BEATS beats (default 4). Slots CHOP_BEATS to BEATS are all ones. Further `beat_valid` cycles before the checksum byte have no effect.
- R4: `crc_valid` after the final beat compares `crc_in` with the local checksum. A difference counts as an error. A match does not.
- R5: An error drives `alert_n` low from the cycle after the compare, for PULSE_CYC cycles (default 8).
- R6: An error that arrives while `alert_n` is low restarts the pulse, so `alert_n` stays low without a break until PULSE_CYC cycles after the latest error.
- R7: `err_count` rises by exactly one for each failing burst and saturates at its maximum value.
- R8: `err_sticky` goes high on the first error and stays high until reset.
- R9: `crc_valid` when no burst is awaiting its checksum is ignored, and so is `beat_valid` outside a burst.
- R10: Synchronous active-high `rst` clears the counter, the sticky flag and the pulse, leaving `alert_n` high.
- R11: Any single-bit, double-bit or odd-count corruption of a burst's data is reported as an error.
- R12: A `burst_start` during a burst abandons it and starts a new one. A beat may come in the same cycle as `burst_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| burst_start | input | 1 | Starts a new burst; samples `chop` |
| chop | input | 1 | Chopped burst of CHOP_BEATS beats |
| beat_valid | input | 1 | `beat_data` holds a beat |
| beat_data | input | LANE_W | One beat of lane data |
| crc_valid | input | 1 | `crc_in` holds the controller checksum |
| crc_in | input | 8 | Checksum sent by the controller |
| alert_n | output | 1 | Active-low error pulse |
| err_count | output | CNT_W | Saturating count of failing bursts |
| err_sticky | output | 1 | Set on any error until reset |

## Verification
The assertions assume that `crc_valid` comes as a strobe after the burst's beats, and they treat any `crc_valid` cycle as the point where a pulse may begin. Under that assumption the run of low `alert_n` cycles after the last `crc_valid` is bounded by PULSE_CYC. The counter is checked to move by at most one per cycle, and the sticky flag to cover every alert. The stimulus drives one-cycle strobes on the falling clock edge. It always sends the checksum after the final expected beat, except where a test deliberately sends a stray strobe, an extra beat or an early restart to show that it is ignored.

// File: rtl/wburst_crc_chk.sv
module wburst_crc_chk #(
  parameter int LANE_W     = 8,
  parameter int BEATS      = 8,
  parameter int CHOP_BEATS = 4,
  parameter int PULSE_CYC  = 8,
  parameter int CNT_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              burst_start,
  input  logic              chop,
  input  logic              beat_valid,
  input  logic [LANE_W-1:0] beat_data,
  input  logic              crc_valid,
  input  logic [7:0]        crc_in,
  output logic              alert_n,
  output logic [CNT_W-1:0]  err_count,
  output logic              err_sticky
);
  localparam int BCNT_W = $clog2(BEATS + 1);
  localparam int TMR_W  = $clog2(PULSE_CYC + 1);
  localparam logic [BCNT_W-1:0] LAST_FULL = BCNT_W'(BEATS - 1);
  localparam logic [BCNT_W-1:0] LAST_CHOP = BCNT_W'(CHOP_BEATS - 1);
  localparam int FILL_FULL = 1;
  localparam int FILL_CHOP = BEATS - CHOP_BEATS + 1;

  typedef enum logic [1:0] {S_IDLE, S_DATA, S_WAIT} state_t;

  function automatic logic [7:0] crc_step(input logic [7:0] c, input logic [LANE_W-1:0] d);
    logic [7:0] r;
    logic fb;
    r = c;
    for (int i = 0; i < LANE_W; i++) begin
      fb = r[7] ^ d[i];
      r  = {r[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return r;
  endfunction

  function automatic logic [7:0] crc_fill(input logic [7:0] c, input int n);
    logic [7:0] r;
    r = c;
    for (int s = 0; s < FILL_CHOP; s++)
      if (s < n) r = crc_step(r, {LANE_W{1'b1}});
    return r;
  endfunction

  state_t state_q;
  logic [7:0] crc_q;
  logic [BCNT_W-1:0] cnt_q;
  logic chop_q;
  logic [TMR_W-1:0] tmr_q;

  logic [7:0] base_crc, step_crc, done_crc;
  logic [BCNT_W-1:0] base_cnt;
  logic base_chop, take, is_last, compare, mismatch;

  assign base_crc  = burst_start ? 8'h00 : crc_q;
  assign base_cnt  = burst_start ? '0 : cnt_q;
  assign base_chop = burst_start ? chop : chop_q;
  assign take      = beat_valid && (burst_start || state_q == S_DATA);
  assign is_last   = base_cnt == (base_chop ? LAST_CHOP : LAST_FULL);
  assign step_crc  = crc_step(base_crc, beat_data);
  assign done_crc  = crc_fill(step_crc, base_chop ? FILL_CHOP : FILL_FULL);
  assign compare   = crc_valid && state_q == S_WAIT;
  assign mismatch  = compare && (crc_in != crc_q);
  assign alert_n   = tmr_q == '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      crc_q   <= 8'h00;
      cnt_q   <= '0;
      chop_q  <= 1'b0;
    end else if (take) begin
      chop_q <= base_chop;
      if (is_last) begin
        crc_q   <= done_crc;
        state_q <= S_WAIT;
      end else begin
        crc_q   <= step_crc;
        cnt_q   <= base_cnt + 1'b1;
        state_q <= S_DATA;
      end
    end else if (burst_start) begin
      chop_q  <= chop;
      crc_q   <= 8'h00;
      cnt_q   <= '0;
      state_q <= S_DATA;
    end else if (compare) begin
      state_q <= S_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tmr_q      <= '0;
      err_count  <= '0;
      err_sticky <= 1'b0;
    end else if (mismatch) begin
      tmr_q      <= TMR_W'(PULSE_CYC);
      err_sticky <= 1'b1;
      if (err_count != {CNT_W{1'b1}}) err_count <= err_count + 1'b1;
    end else if (tmr_q != '0) begin
      tmr_q <= tmr_q - 1'b1;
    end
  end
endmodule

// File: rtl/wburst_crc_chk_sva.sv
module wburst_crc_chk_sva #(
  parameter int PULSE_CYC = 8,
  parameter int CNT_W     = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             crc_valid,
  input logic             alert_n,
  input logic [CNT_W-1:0] err_count,
  input logic             err_sticky
);
  logic [15:0] low_run;
  always_ff @(posedge clk) begin
    if (rst || crc_valid) low_run <= '0;
    else if (!alert_n)    low_run <= low_run + 1'b1;
    else                  low_run <= '0;
  end

  // R5
  pulse_bound_chk: assert property (@(posedge clk) disable iff (rst) low_run <= 16'(PULSE_CYC));
  // R8
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst) err_sticky |=> err_sticky);
  // R8
  alert_sticky_chk: assert property (@(posedge clk) disable iff (rst) !alert_n |-> err_sticky);
  // R7
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (err_count == $past(err_count) || err_count == $past(err_count) + 1'b1));
  // R10
  reset_clear_chk: assert property (@(posedge clk) $past(rst) |-> (alert_n && err_count == '0 && !err_sticky));
endmodule

bind wburst_crc_chk wburst_crc_chk_sva #(.PULSE_CYC(PULSE_CYC), .CNT_W(CNT_W)) sva_i (
  .clk(clk), .rst(rst), .crc_valid(crc_valid), .alert_n(alert_n),
  .err_count(err_count), .err_sticky(err_sticky)
);

// File: tb/wburst_crc_chk_test.sv
module wburst_crc_chk_test;
  localparam int CLK_PERIOD = 10;
  localparam int PULSE = 8;

  logic clk = 1'b0, rst = 1'b1, burst_start = 1'b0, chop = 1'b0, beat_valid = 1'b0, crc_valid = 1'b0;
  logic [7:0] beat_data = 8'h00, crc_in = 8'h00;
  logic alert_n, err_sticky;
  logic [7:0] err_count;

  wburst_crc_chk uut (
    .clk(clk), .rst(rst), .burst_start(burst_start), .chop(chop), .beat_valid(beat_valid),
    .beat_data(beat_data), .crc_valid(crc_valid), .crc_in(crc_in), .alert_n(alert_n),
    .err_count(err_count), .err_sticky(err_sticky));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, mcount = 0, cyc = 0, streak = 0, last_streak = 0;
  int last_t = 0, prev_t = 0;
  bit expq[$];
  logic cv_s = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_crc(input logic [63:0] d, input bit ch);
    logic [7:0] c = 8'h00;
    logic b, fb;
    for (int s = 0; s < 9; s++)
      for (int i = 0; i < 8; i++) begin
        b  = (s == 8 || (ch && s >= 4)) ? 1'b1 : d[s*8+i];
        fb = c[7] ^ b;
        c  = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
      end
    return c;
  endfunction

  always @(posedge clk) begin cyc++; cv_s <= crc_valid; end

  always @(negedge clk) begin
    if (!alert_n) streak++;
    else if (streak != 0) begin last_streak = streak; streak = 0; end
  end

  always @(negedge clk) if (cv_s && expq.size() > 0) begin
    bit e;
    e = expq.pop_front();
    if (e) begin
      if (mcount < 255) mcount++;
      prev_t = last_t; last_t = cyc;
      chk(alert_n == 1'b0, "R5 alert low after error", alert_n, 0);
      chk(err_sticky == 1'b1, "R8 sticky after error", err_sticky, 1);
    end
    chk(err_count == mcount, "R4/R7 error count", err_count, mcount);
  end

  task automatic burst(input logic [63:0] d, input bit ch, input logic [7:0] crc, input bit exp, input int extra);
    int n;
    n = ch ? 4 : 8;
    @(negedge clk); burst_start = 1; chop = ch;
    @(negedge clk); burst_start = 0; chop = 0;
    for (int k = 0; k < n + extra; k++) begin
      beat_valid = 1; beat_data = (k < n) ? d[k*8 +: 8] : 8'h5A ^ 8'(k);
      @(negedge clk);
    end
    beat_valid = 0;
    expq.push_back(exp);
    crc_valid = 1; crc_in = crc;
    @(negedge clk); crc_valid = 0;
  endtask

  task automatic idle(input int n); repeat (n) @(negedge clk); endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [63:0] d;
    repeat (3) @(negedge clk);
    rst = 0;
    // R10 reset state
    chk(alert_n == 1, "R10 alert_n reset", alert_n, 1);
    chk(err_count == 0, "R10 count reset", err_count, 0);
    chk(err_sticky == 0, "R10 sticky reset", err_sticky, 0);

    // R1 R2 R4 good bursts
    burst(64'h0, 0, ref_crc(64'h0, 0), 0, 0);
    burst('1, 0, ref_crc('1, 0), 0, 0);
    burst(64'h0123_4567_89AB_CDEF, 0, ref_crc(64'h0123_4567_89AB_CDEF, 0), 0, 0);
    burst(64'hA5C3_0F1E_7788_9911, 0, ref_crc(64'hA5C3_0F1E_7788_9911, 0), 0, 0);
    idle(2);
    chk(alert_n == 1 && err_sticky == 0, "R4 no alert on match", alert_n, 1);

    // R1 bit order: a single bit in slot 0 position 0 vs position 7 gives distinct checksums
    d = 64'h1;
    burst(d, 0, ref_crc(d, 0), 0, 0);
    chk(ref_crc(64'h1, 0) != ref_crc(64'h80, 0), "R1 bit order model", 0, 1);
    burst(64'h80, 0, ref_crc(64'h1, 0), 1, 0);
    idle(14);
    // R5 pulse width
    chk(last_streak == PULSE, "R5 pulse width", last_streak, PULSE);

    // R3 chop with ignored extra beats
    d = 64'hDEAD_BEEF_CAFE_F00D;
    burst(d, 1, ref_crc(d, 1), 0, 3);
    burst(d, 1, ref_crc(d, 0), 1, 0);
    idle(14);

    // R9 stray crc_valid and stray beats
    expq.push_back(0);
    @(negedge clk); crc_valid = 1; crc_in = 8'h3C;
    @(negedge clk); crc_valid = 0;
    chk(alert_n == 1, "R9 stray crc ignored alert", alert_n, 1);
    @(negedge clk); beat_valid = 1; beat_data = 8'hFF;
    @(negedge clk); beat_valid = 0;
    d = 64'h1122_3344_5566_7788;
    burst(d, 0, ref_crc(d, 0), 0, 0);
    idle(2);
    chk(alert_n == 1, "R9 stray beat ignored", alert_n, 1);

    // R12 restart mid-burst, then beat alongside start
    @(negedge clk); burst_start = 1;
    @(negedge clk); burst_start = 0; beat_valid = 1; beat_data = 8'hEE;
    @(negedge clk); beat_data = 8'h77;
    @(negedge clk); beat_valid = 0;
    burst(d, 0, ref_crc(d, 0), 0, 0);
    @(negedge clk); burst_start = 1; beat_valid = 1; beat_data = d[7:0];
    for (int k = 1; k < 8; k++) begin
      @(negedge clk); burst_start = 0; beat_data = d[k*8 +: 8];
    end
    @(negedge clk); beat_valid = 0; expq.push_back(0); crc_valid = 1; crc_in = ref_crc(d, 0);
    @(negedge clk); crc_valid = 0;
    idle(2);
    chk(alert_n == 1, "R12 beat with start", alert_n, 1);

    // R11 single, double, triple flips
    d = 64'h0F0F_3355_AA00_C3E1;
    for (int f = 0; f < 64; f += 9) burst(d ^ (64'h1 << f), 0, ref_crc(d, 0), 1, 0);
    burst(d ^ 64'h8000_0000_0000_0001, 0, ref_crc(d, 0), 1, 0);
    burst(d ^ 64'h0000_0100_0000_0100, 0, ref_crc(d, 0), 1, 0);
    burst(d ^ 64'h0010_0000_0200_0004, 0, ref_crc(d, 0), 1, 0);
    idle(14);

    // R6 extension: two chopped failing bursts close together
    burst(d, 1, ~ref_crc(d, 1), 1, 0);
    burst(d, 1, ~ref_crc(d, 1), 1, 0);
    idle(14);
    chk(last_streak == (last_t - prev_t) + PULSE, "R6 pulse extended", last_streak, (last_t - prev_t) + PULSE);

    // R8 sticky holds after good burst
    burst(d, 0, ref_crc(d, 0), 0, 0);
    idle(12);
    chk(err_sticky == 1 && alert_n == 1, "R8 sticky holds", err_sticky, 1);

    // R7 saturation
    for (int k = 0; k < 260; k++) burst(d, 1, ~ref_crc(d, 1), 1, 0);
    idle(12);
    chk(err_count == 255, "R7 saturate", err_count, 255);

    // R10 reset mid-operation
    burst(d, 1, ~ref_crc(d, 1), 1, 0);
    rst = 1; @(negedge clk); rst = 0; mcount = 0;
    chk(alert_n == 1 && err_count == 0 && err_sticky == 0, "R10 reset clears", err_count, 0);

    idle(4);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule